// File: doc/BRIEF.md
# Per-Gene Operator Select Generator

This block produces, for every gene streamed through a genetic datapath, the six select bits that steer that datapath: which parent the gene is inherited from, uniform versus gaussian noise, scaling, random versus constant value, replace versus add, and whether mutation happens at all. Each select bit is read from a one-bit-wide, 256-entry truth table that software loads. The whole evolutionary operator is therefore a set of six 8-input boolean functions.

The 8-bit table address is built for each gene from three sources. Two crossover mask bits come from two independent mask channels, each fed by a small command queue. A command is either a run of zeros, a run of ones, or a word of packed mask bits. Two random bits are each 1 when a 10-bit random sample is below an 11-bit probability register given in units of 1/1024. Four bits are the parent genes' steering flags, two from the mother and two from the father. A gene is accepted on a valid/ready handshake, and its select word appears one cycle later.

Top module: `evo_ctrl_gen`

## Requirements
- R1: After reset, `sel_valid` and `gene_ready` are 0, `cmd_ready` is 1, and all six tables hold 0.
- R2: While `lut_we` is 1 at a clock edge, entry `lut_addr` of table `lut_sel` takes `lut_wdata`, for `lut_sel` values 0 to 5. A write with `lut_sel` of 6 or 7 changes no table.
- R3: The table address is ordered as follows. Bit 0 is mask channel 0 and bit 1 is mask channel 1. Bit 2 is random bit 1 and bit 3 is random bit 2. Bits 5:4 are `mother_flags[1:0]` and bits 7:6 are `father_flags[1:0]`.
- R4: When a gene is accepted (`gene_valid` and `gene_ready` both 1 at an edge), `sel_valid` is 1 after that edge and `sel_word[j]` holds table j at that gene's address. `sel_word` holds its value while no gene is accepted. The `sel_word` bit order is: 0 parent, 1 noise kind, 2 scale, 3 constant, 4 replace, 5 mutate.
- R5: Random bit k is 1 exactly when the 10-bit sample is less than its probability register. Sample 1 is `rnd_word[9:0]` against `prob1`, and sample 2 is `rnd_word[19:10]` against `prob2`. So a probability of 1024 always gives 1 and a probability of 0 never does.
- R6: A command with `cmd_kind` 0 emits `cmd_arg` zero mask bits and `cmd_kind` 1 emits `cmd_arg` one bits. Each accepted gene consumes one bit from each channel, and a channel's commands play out in the order they were given.
- R7: A command with `cmd_kind` 2 emits the 16 bits of `cmd_arg`, bit 0 first.
- R8: A run command with count 0 and any command with `cmd_kind` 3 are accepted and emit nothing.
- R9: `gene_ready` is 0 while either channel has no mask bit. `cmd_ready` is 0 while the queue of the channel picked by `cmd_chan` is full. A channel holds four queued commands plus the one it is playing out.
- R10: `cmd_chan` 0 feeds address bit 0 and `cmd_chan` 1 feeds address bit 1. The two channels are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lut_we | input | 1 | Table write strobe |
| lut_sel | input | 3 | Table to write (0 to 5) |
| lut_addr | input | 8 | Entry to write |
| lut_wdata | input | 1 | Entry value |
| prob1 | input | 11 | Probability of random bit 1, per 1024 |
| prob2 | input | 11 | Probability of random bit 2, per 1024 |
| rnd_word | input | 20 | Two 10-bit random samples |
| cmd_valid | input | 1 | Mask command offered |
| cmd_chan | input | 1 | Mask channel of the command |
| cmd_kind | input | 2 | 0 run of zeros, 1 run of ones, 2 packed bits, 3 ignored |
| cmd_arg | input | 16 | Run length or packed bits |
| cmd_ready | output | 1 | Selected channel can take a command |
| gene_valid | input | 1 | Gene offered |
| mother_flags | input | 2 | Mother gene steering flags |
| father_flags | input | 2 | Father gene steering flags |
| gene_ready | output | 1 | Both mask bits are available |
| sel_valid | output | 1 | Select word is new this cycle |
| sel_word | output | 6 | Datapath select bits |

## Verification
The bench codes a two-point crossover as runs of 27, 51 and 50. A run off by one shifts the crossover point and puts the wrong parent bit on neighbouring genes. It loads tables that pass individual address bits straight through to the outputs, so a swapped address field or an off-by-one probability compare (`<=` instead of `<`) shows up at 51 against a sample of 50 and 51, and at the 0 and 1024 limits. Zero-length runs and reserved commands are placed between real runs, where a design that queued them would stall or emit extra bits. A full queue on one channel and an empty one on the other must hold off commands and genes without producing a select word.

// File: rtl/evo_ctrl_pkg.sv
package evo_ctrl_pkg;
   localparam int N_SEL = 6;
   localparam int N_ECB = 8;

   typedef enum logic [1:0] {
      MK_RUN0 = 2'd0,
      MK_RUN1 = 2'd1,
      MK_BIN  = 2'd2,
      MK_RSV  = 2'd3
   } mask_kind_e;

   // table address layout, LSB last field (R3)
   typedef struct packed {
      logic [1:0] father;
      logic [1:0] mother;
      logic [1:0] rnd;
      logic [1:0] mask;
   } ecb_addr_t;
endpackage

// File: rtl/evo_sel_lut.sv
module evo_sel_lut #(
   parameter int N_TBL  = 6,
   parameter int ADDR_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [$clog2(N_TBL)-1:0]  wr_tbl,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic                      wr_data,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [N_TBL-1:0]          rd_bits
);
   localparam int TBL_W   = $clog2(N_TBL);
   localparam int ENTRIES = 1 << ADDR_W;

   if (N_TBL < 2)   $error("evo_sel_lut: N_TBL must be at least 2");
   if (ADDR_W > 10) $error("evo_sel_lut: ADDR_W too large for flop tables");

   for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
      logic [ENTRIES-1:0] tbl;
      // R2: only table indices that exist are decoded
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tbl <= '0;
         else if (wr_en && (wr_tbl == TBL_W'(g)))
            tbl[wr_addr] <= wr_data;
      end
      assign rd_bits[g] = tbl[rd_addr];
   end
endmodule

// File: rtl/evo_rand_bits.sv
module evo_rand_bits #(
   parameter int N_BITS = 2,
   parameter int RND_W  = 10
) (
   input  logic [N_BITS*RND_W-1:0]     rnd,
   input  logic [N_BITS*(RND_W+1)-1:0] prob,
   output logic [N_BITS-1:0]           hit
);
   localparam int PW = RND_W + 1;

   if (RND_W < 2) $error("evo_rand_bits: RND_W too small");

   // R5: strict compare, so full scale (1 << RND_W) always hits
   for (genvar g = 0; g < N_BITS; g++) begin : g_cmp
      assign hit[g] = ({1'b0, rnd[g*RND_W +: RND_W]} < prob[g*PW +: PW]);
   end
endmodule

// File: rtl/evo_mask_expander.sv
module evo_mask_expander
   import evo_ctrl_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int ARG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_valid,
   input  logic [1:0]       push_kind,
   input  logic [ARG_W-1:0] push_arg,
   output logic             push_ready,
   output logic             bit_avail,
   output logic             bit_val,
   input  logic             bit_take
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1)  $error("evo_mask_expander: DEPTH must be at least 1");
   if (ARG_W < 2)  $error("evo_mask_expander: ARG_W too small");

   typedef struct packed {
      logic [1:0]       kind;
      logic [ARG_W-1:0] arg;
   } cmd_t;

   cmd_t              q [DEPTH];
   logic [PTR_W-1:0]  wp, rp;
   logic [CNT_W-1:0]  cnt;

   logic              active, cur_bin, cur_one;
   logic [ARG_W-1:0]  shift, left;
   logic              is_run, keep, store, pop, last;
   cmd_t              head;

   assign push_ready = (cnt != CNT_W'(DEPTH));
   assign is_run     = (push_kind == MK_RUN0) || (push_kind == MK_RUN1);
   // R8: empty runs and reserved kinds are swallowed at the door
   assign keep       = is_run ? (push_arg != '0) : (push_kind == MK_BIN);
   assign store      = push_valid && push_ready && keep;
   assign last       = (left == ARG_W'(1));
   assign pop        = (!active || (bit_take && last)) && (cnt != '0);
   assign head       = q[rp];

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (store) q[wp] <= '{kind: push_kind, arg: push_arg};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp      <= '0;
         rp      <= '0;
         cnt     <= '0;
         active  <= 1'b0;
         cur_bin <= 1'b0;
         cur_one <= 1'b0;
         shift   <= '0;
         left    <= '0;
      end else begin
         if (store) wp <= nxt(wp);
         if (pop)   rp <= nxt(rp);
         cnt <= cnt + CNT_W'(store) - CNT_W'(pop);
         if (pop) begin
            active  <= 1'b1;
            cur_bin <= (head.kind == MK_BIN);
            cur_one <= (head.kind == MK_RUN1);
            shift   <= head.arg;
            left    <= (head.kind == MK_BIN) ? ARG_W'(ARG_W) : head.arg;
         end else if (bit_take) begin
            if (last) active <= 1'b0;
            left  <= left - ARG_W'(1);
            shift <= shift >> 1;
         end
      end
   end

   // R6 R7: runs repeat one value, packed words shift out LSB first
   assign bit_avail = active;
   assign bit_val   = cur_bin ? shift[0] : cur_one;
endmodule

// File: rtl/evo_ctrl_gen.sv
module evo_ctrl_gen
   import evo_ctrl_pkg::*;
#(
   parameter int MASK_DEPTH = 4,
   parameter int ARG_W      = 16,
   parameter int RND_W      = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lut_we,
   input  logic [2:0]           lut_sel,
   input  logic [N_ECB-1:0]     lut_addr,
   input  logic                 lut_wdata,
   input  logic [RND_W:0]       prob1,
   input  logic [RND_W:0]       prob2,
   input  logic [2*RND_W-1:0]   rnd_word,
   input  logic                 cmd_valid,
   input  logic                 cmd_chan,
   input  logic [1:0]           cmd_kind,
   input  logic [ARG_W-1:0]     cmd_arg,
   output logic                 cmd_ready,
   input  logic                 gene_valid,
   input  logic [1:0]           mother_flags,
   input  logic [1:0]           father_flags,
   output logic                 gene_ready,
   output logic                 sel_valid,
   output logic [N_SEL-1:0]     sel_word
);
   localparam int N_CH = 2;

   if ($clog2(N_SEL) != 3) $error("evo_ctrl_gen: lut_sel width mismatch");

   logic [N_CH-1:0]  ch_rdy, ch_avail, ch_bit;
   logic [1:0]       rbit;
   logic             accept;
   ecb_addr_t        addr_s;
   logic [N_SEL-1:0] lut_bits;

   // R10: one expander per mask channel
   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      evo_mask_expander #(.DEPTH(MASK_DEPTH), .ARG_W(ARG_W)) u_exp (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_valid (cmd_valid && (cmd_chan == 1'(c))),
         .push_kind  (cmd_kind),
         .push_arg   (cmd_arg),
         .push_ready (ch_rdy[c]),
         .bit_avail  (ch_avail[c]),
         .bit_val    (ch_bit[c]),
         .bit_take   (accept)
      );
   end

   assign cmd_ready  = ch_rdy[cmd_chan];
   assign gene_ready = &ch_avail;          // R9
   assign accept     = gene_valid && gene_ready;

   evo_rand_bits #(.N_BITS(2), .RND_W(RND_W)) u_rnd (
      .rnd  (rnd_word),
      .prob ({prob2, prob1}),
      .hit  (rbit)
   );

   always_comb begin
      addr_s.mask   = ch_bit;
      addr_s.rnd    = rbit;
      addr_s.mother = mother_flags;
      addr_s.father = father_flags;
   end

   evo_sel_lut #(.N_TBL(N_SEL), .ADDR_W(N_ECB)) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (lut_we),
      .wr_tbl  (lut_sel),
      .wr_addr (lut_addr),
      .wr_data (lut_wdata),
      .rd_addr (addr_s),
      .rd_bits (lut_bits)
   );

   // R4: one register stage from accepted gene to select word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_word  <= '0;
      end else begin
         sel_valid <= accept;
         if (accept) sel_word <= lut_bits;
      end
   end
endmodule

// File: rtl/evo_ctrl_gen_chk.sv
module evo_ctrl_gen_chk #(
   parameter int RND_W = 10
) (
   input logic           clk,
   input logic           rst_n,
   input logic           gene_valid,
   input logic           gene_ready,
   input logic           sel_valid,
   input logic [5:0]     sel_word,
   input logic [RND_W:0] prob1,
   input logic [RND_W:0] prob2,
   input logic [1:0]     rbit
);
   assert_valid_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> $past(gene_valid && gene_ready));

   assert_accept_gives_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gene_valid && gene_ready) |=> sel_valid);

   assert_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gene_valid && gene_ready) |=> $stable(sel_word));

   assert_rand1_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prob1[RND_W] |-> rbit[0]);

   assert_rand2_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prob2[RND_W] |-> rbit[1]);

   assert_rand1_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prob1 == '0) |-> !rbit[0]);

   assert_rand2_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prob2 == '0) |-> !rbit[1]);
endmodule

bind evo_ctrl_gen evo_ctrl_gen_chk #(.RND_W(RND_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gene_valid (gene_valid),
   .gene_ready (gene_ready),
   .sel_valid  (sel_valid),
   .sel_word   (sel_word),
   .prob1      (prob1),
   .prob2      (prob2),
   .rbit       (rbit)
);

// File: tb/evo_ctrl_gen_tb.sv
module evo_ctrl_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lut_we = 1'b0;
   logic [2:0]  lut_sel = '0;
   logic [7:0]  lut_addr = '0;
   logic        lut_wdata = 1'b0;
   logic [10:0] prob1 = '0, prob2 = '0;
   logic [19:0] rnd_word = '0;
   logic        cmd_valid = 1'b0, cmd_chan = 1'b0;
   logic [1:0]  cmd_kind = '0;
   logic [15:0] cmd_arg = '0;
   logic        cmd_ready;
   logic        gene_valid = 1'b0;
   logic [1:0]  mother_flags = '0, father_flags = '0;
   logic        gene_ready, sel_valid;
   logic [5:0]  sel_word;

   evo_ctrl_gen u_dut (
      .clk(clk), .rst_n(rst_n), .lut_we(lut_we), .lut_sel(lut_sel),
      .lut_addr(lut_addr), .lut_wdata(lut_wdata), .prob1(prob1), .prob2(prob2),
      .rnd_word(rnd_word), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
      .cmd_kind(cmd_kind), .cmd_arg(cmd_arg), .cmd_ready(cmd_ready),
      .gene_valid(gene_valid), .mother_flags(mother_flags),
      .father_flags(father_flags), .gene_ready(gene_ready),
      .sel_valid(sel_valid), .sel_word(sel_word)
   );

   always #4 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit lm [6][256];
   bit q0 [$];
   bit q1 [$];

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0d exp<=60000", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic bit mix(input int j, input int a);
      return bit'(((a * 37 + j * 91 + (a >> 4) * 5 + (a >> 6) * 17) >> 2) & 1);
   endfunction

   task automatic lut_wr(input int j, input int a, input bit d);
      @(negedge clk);
      lut_we = 1'b1; lut_sel = 3'(j); lut_addr = 8'(a); lut_wdata = d;
      @(posedge clk);
      if (j < 6) lm[j][a] = d;
      @(negedge clk);
      lut_we = 1'b0;
   endtask

   task automatic push(input int ch, input int kind, input int arg);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_chan = 1'(ch); cmd_kind = 2'(kind); cmd_arg = 16'(arg);
      #1;
      while (!cmd_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      if ((kind == 0 || kind == 1) && arg != 0) begin
         for (int i = 0; i < arg; i++)
            if (ch == 0) q0.push_back(bit'(kind)); else q1.push_back(bit'(kind));
      end else if (kind == 2) begin
         for (int i = 0; i < 16; i++)
            if (ch == 0) q0.push_back(bit'((arg >> i) & 1)); else q1.push_back(bit'((arg >> i) & 1));
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // drives one gene, returns the expected word and checks it
   task automatic gene(input bit [1:0] m, input bit [1:0] f, input int r1, input int r2,
                       input string req, output logic [5:0] expw);
      logic [7:0] a;
      bit rb1, rb2, mb0, mb1;
      @(negedge clk);
      gene_valid = 1'b1; mother_flags = m; father_flags = f;
      rnd_word = {10'(r2), 10'(r1)};
      #1;
      while (!gene_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      mb0 = q0.pop_front();
      mb1 = q1.pop_front();
      rb1 = (r1 < int'(prob1));
      rb2 = (r2 < int'(prob2));
      a = {f, m, rb2, rb1, mb1, mb0};
      for (int j = 0; j < 6; j++) expw[j] = lm[j][a];
      @(negedge clk);
      gene_valid = 1'b0;
      check(sel_valid === 1'b1, {req, " sel_valid after accept (R4)"}, int'(sel_valid), 1);
      check(sel_word === expw, {req, " sel_word"}, int'(sel_word), int'(expw));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(sel_valid === 1'b0, "R1 sel_valid", int'(sel_valid), 0);
      check(gene_ready === 1'b0, "R1 gene_ready", int'(gene_ready), 0);
      check(cmd_ready === 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
      check(sel_word === 6'd0, "R1 sel_word", int'(sel_word), 0);
   endtask

   task automatic t_zero_tables();
      logic [5:0] w;
      prob1 = 11'd1024; prob2 = 11'd1024;
      push(0, 1, 1); push(1, 1, 1);
      gene(2'b11, 2'b11, 0, 0, "R1 cleared tables", w);
   endtask

   task automatic t_load_mix();
      for (int j = 0; j < 6; j++)
         for (int a = 0; a < 256; a++) lut_wr(j, a, mix(j, a));
   endtask

   task automatic t_load_probe();
      for (int j = 0; j < 6; j++)
         for (int a = 0; a < 256; a++) lut_wr(j, a, bit'((a >> j) & 1));
   endtask

   task automatic t_lut_ignore();
      logic [5:0] w;
      lut_wr(6, 8'hA5, ~lm[0][8'hA5]);
      lut_wr(7, 8'hA5, ~lm[1][8'hA5]);
      prob1 = 11'd1024; prob2 = 11'd0;
      push(0, 1, 1); push(1, 0, 1);
      gene(2'b10, 2'b10, 5, 5, "R2 table index 6/7 ignored", w);
   endtask

   task automatic t_main();
      logic [5:0] w;
      prob1 = 11'd51; prob2 = 11'd512;
      push(0, 0, 27); push(0, 1, 51); push(0, 0, 50);
      for (int k = 0; k < 4; k++) push(1, 2, 16'hC35A ^ (k * 16'h1111));
      for (int i = 0; i < 64; i++)
         gene(2'(i), 2'(i >> 2), (i * 97) % 1024, (i * 331) % 1024, "R3 R6 R7 R10 main", w);
      for (int k = 4; k < 8; k++) push(1, 2, 16'hC35A ^ (k * 16'h1111));
      for (int i = 64; i < 128; i++)
         gene(2'(i), 2'(i >> 2), (i * 97) % 1024, (i * 331) % 1024, "R3 R6 R7 R10 main", w);
   endtask

   task automatic t_prob();
      logic [5:0] w;
      push(0, 0, 4); push(1, 1, 4);
      prob1 = 11'd1024; prob2 = 11'd0;
      gene(2'b00, 2'b00, 1023, 0, "R5 full/zero", w);
      check(sel_word[2] === 1'b1, "R5 prob 1024 always", int'(sel_word[2]), 1);
      check(sel_word[3] === 1'b0, "R5 prob 0 never", int'(sel_word[3]), 0);
      prob1 = 11'd51; prob2 = 11'd51;
      gene(2'b01, 2'b00, 50, 51, "R5 threshold", w);
      check(sel_word[2] === 1'b1, "R5 sample 50 < 51", int'(sel_word[2]), 1);
      check(sel_word[3] === 1'b0, "R5 sample 51 not < 51", int'(sel_word[3]), 0);
      check(sel_word[4] === 1'b1, "R3 mother bit 4", int'(sel_word[4]), 1);
      gene(2'b10, 2'b00, 51, 50, "R5 threshold swap", w);
      check(sel_word[3:2] === 2'b10, "R5 swapped samples", int'(sel_word[3:2]), 2);
      gene(2'b00, 2'b00, 0, 0, "R5 zero sample", w);
      check(sel_word[1:0] === 2'b10, "R10 channel bits", int'(sel_word[1:0]), 2);
   endtask

   task automatic t_zero_run();
      logic [5:0] w;
      bit expm [6] = '{1, 1, 1, 1, 1, 0};
      prob1 = 11'd0; prob2 = 11'd0;
      push(0, 1, 3); push(0, 0, 0); push(0, 1, 2); push(0, 3, 5); push(0, 0, 1);
      push(1, 0, 6);
      for (int i = 0; i < 6; i++) begin
         gene(2'b00, 2'b00, 0, 0, "R8 empty runs dropped", w);
         check(sel_word[0] === expm[i], "R8 mask sequence", int'(sel_word[0]), int'(expm[i]));
      end
   endtask

   task automatic t_backpressure();
      logic [5:0] w;
      push(1, 2, 16'h1234);
      repeat (3) @(negedge clk);
      for (int k = 0; k < 4; k++) push(1, 2, 16'hA5F0 + k);
      @(negedge clk);
      cmd_chan = 1'b1; #1;
      check(cmd_ready === 1'b0, "R9 full channel not ready", int'(cmd_ready), 0);
      cmd_chan = 1'b0; #1;
      check(cmd_ready === 1'b1, "R9 R10 other channel ready", int'(cmd_ready), 1);
      gene_valid = 1'b1; #1;
      check(gene_ready === 1'b0, "R9 empty channel blocks gene", int'(gene_ready), 0);
      repeat (3) begin
         @(negedge clk);
         check(sel_valid === 1'b0, "R9 no word while blocked", int'(sel_valid), 0);
      end
      gene_valid = 1'b0;
      push(0, 1, 40); push(0, 0, 40);
      for (int i = 0; i < 80; i++)
         gene(2'(i >> 1), 2'(i), 0, 0, "R9 drain", w);
      @(negedge clk);
      check(sel_valid === 1'b0, "R4 valid drops when idle", int'(sel_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_zero_tables();
      t_load_mix();
      t_lut_ignore();
      t_main();
      t_load_probe();
      t_prob();
      t_zero_run();
      t_backpressure();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule